// File: doc/BRIEF.md
# Serial Line Encoder with Automatic Preamble

This block turns a serial transmit bit stream into a line-coded output. Bits arrive one at a time over a valid/ready handshake, and the block emits them in one of seven line codes: plain NRZ, two NRZI variants, two bi-phase space/mark codes (FM0, FM1), Manchester and differential Manchester. Each bit is built from two half-bit symbols. The block is paced by a strobe `half_en`, which pulses at twice the bit rate. A new bit is taken on every second strobe.

When a frame starts after the line has been idle, the block can first send a short lock-up pattern. Its content is chosen automatically from the active line code. Its length is programmable and is capped at `PRE_MAX` bits. The data polarity can be inverted. When no data is offered, the idle line is either pulled high or keeps encoding a supplied idle bit.

Top module: `lenc_top`

## Requirements
- R1: During and right after reset, `line_out` is 1, and `s_ready` is 0 whenever `half_en` is 0. The first `half_en` after reset starts a bit slot.
- R2: Each bit slot spans two `half_en` pulses. `s_ready` can be 1 only in the cycle of the first pulse. `line_out` changes only in the cycle after a `half_en` pulse.
- R3: Mode codes are 0 NRZ, 1 NRZI-mark, 2 NRZI-space and 7 (treated as NRZ). In NRZ both halves equal the bit. NRZI-mark toggles the level for a 1, and NRZI-space toggles it for a 0. None of these has a mid-bit change.
- R4: Mode 3 (FM0) and mode 4 (FM1) toggle the level at every bit start. FM0 toggles it again mid-bit for a 0, and FM1 does so for a 1.
- R5: Mode 5 (Manchester) sends a 1 as high then low and a 0 as low then high. Mode 6 (differential Manchester) toggles the level mid-bit always, and also at bit start for a 0.
- R6: A frame starts when `s_valid` is 1 at a slot start while no frame is open. If `cfg_pre_en` is 1 and the length is nonzero, min(`cfg_pre_len`, `PRE_MAX`) lock-up slots are sent first, with `s_ready` held at 0. The first data bit is then taken in the next slot.
- R7: The lock-up bits are all ones for NRZ, NRZI-space, FM0, differential Manchester and reserved. They are all zeros for NRZI-mark and FM1. For Manchester they are 1,0,1,0… starting with 1. These bits are encoded with the active code.
- R8: A frame closes when a bit with `s_last`=1 is taken. A gap inside an open frame sends no lock-up bits. The next frame after a close sends them again.
- R9: When `cfg_invert` is 1, data bits and encoded idle bits are complemented before encoding. Lock-up bits and the forced-high idle level are not complemented.
- R10: In a slot with no lock-up bit and no taken data, `cfg_idle_high`=1 drives 1 for both halves and sets the reference level to 1. Otherwise `idle_bit` is encoded with the active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Strobe at twice the bit rate |
| cfg_mode | input | 3 | Line code select (see R3 to R5) |
| cfg_pre_en | input | 1 | Enables the lock-up pattern |
| cfg_pre_len | input | LEN_W | Lock-up length in bits |
| cfg_invert | input | 1 | Complements data and idle bits |
| cfg_idle_high | input | 1 | 1: idle line high; 0: encode idle_bit |
| idle_bit | input | 1 | Bit encoded on an idle line |
| s_valid | input | 1 | Data bit offered |
| s_data | input | 1 | Data bit |
| s_last | input | 1 | Marks the last bit of a frame |
| s_ready | output | 1 | Data bit taken this cycle when s_valid is 1 |
| line_out | output | 1 | Encoded line level |

## Verification
The bench uses the defaults `PRE_MAX`=8 and `LEN_W`=4. A 4-bit length field can therefore request 12 bits, which tests the clamp to 8. Lengths of 0, 4 and 8 cover the other boundaries. Every line code is driven through a full frame that begins from a known high level. This makes every boundary and mid-bit transition predictable. Sequences of several frames, mid-frame gaps and both idle behaviours cover reopening a frame and the rules on inversion.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

  typedef enum logic [2:0] {
    ENC_NRZ    = 3'd0,
    ENC_NRZI_M = 3'd1,
    ENC_NRZI_S = 3'd2,
    ENC_FM0    = 3'd3,
    ENC_FM1    = 3'd4,
    ENC_MAN    = 3'd5,
    ENC_DMAN   = 3'd6,
    ENC_RSVD   = 3'd7
  } enc_mode_e;

  // Lock-up pattern bit for a code; odd selects the alternate position.
  function automatic logic pre_pattern(enc_mode_e m, logic odd);
    logic r;
    case (m)
      ENC_NRZI_M, ENC_FM1: r = 1'b0;
      ENC_MAN:             r = ~odd;
      default:             r = 1'b1;
    endcase
    return r;
  endfunction

  // Two half-bit levels {first, second} for bit b starting from level lvl.
  function automatic logic [1:0] encode_halves(enc_mode_e m, logic b, logic lvl);
    logic f;
    logic [1:0] r;
    case (m)
      ENC_NRZI_M: begin f = lvl ^ b;      r = {f, f}; end
      ENC_NRZI_S: begin f = lvl ^ ~b;     r = {f, f}; end
      ENC_FM0:    begin f = ~lvl;         r = {f, b ? f : ~f}; end
      ENC_FM1:    begin f = ~lvl;         r = {f, b ? ~f : f}; end
      ENC_MAN:    begin f = b;            r = {f, ~f}; end
      ENC_DMAN:   begin f = b ? lvl : ~lvl; r = {f, ~f}; end
      default:    begin f = b;            r = {f, f}; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lenc_phase.sv
module lenc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  output logic slot_start,
  output logic slot_mid
);
  logic second_half;

  always_ff @(posedge clk) begin
    if (!rst_n)       second_half <= 1'b0;
    else if (half_en) second_half <= ~second_half;
  end

  assign slot_start = half_en & ~second_half;
  assign slot_mid   = half_en &  second_half;
endmodule

// File: rtl/lenc_seq.sv
module lenc_seq
  import lenc_pkg::*;
#(
  parameter int PRE_MAX = 8,
  parameter int LEN_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  enc_mode_e        mode,
  input  logic             cfg_pre_en,
  input  logic [LEN_W-1:0] cfg_pre_len,
  input  logic             cfg_invert,
  input  logic             cfg_idle_high,
  input  logic             idle_bit,
  input  logic             s_valid,
  input  logic             s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             accept,
  output logic             pre_active,
  output logic             force_idle,
  output logic             enc_bit,
  output logic             frame_open
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(PRE_MAX);

  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] pre_left;
  logic             pre_odd;
  logic             pre_cont;
  logic             start_pre;
  logic             cur_odd;

  assign len_eff    = (cfg_pre_len > LEN_CAP) ? LEN_CAP : cfg_pre_len;
  assign pre_cont   = (pre_left != '0);
  assign start_pre  = slot_start & ~frame_open & ~pre_cont & s_valid
                    & cfg_pre_en & (len_eff != '0);
  assign pre_active = slot_start & (start_pre | pre_cont);
  assign s_ready    = slot_start & ~pre_active;
  assign accept     = s_ready & s_valid;
  assign force_idle = slot_start & ~pre_active & ~accept & cfg_idle_high;
  assign cur_odd    = start_pre ? 1'b0 : pre_odd;

  always_comb begin
    if (pre_active)  enc_bit = pre_pattern(mode, cur_odd);
    else if (accept) enc_bit = s_data ^ cfg_invert;
    else             enc_bit = idle_bit ^ cfg_invert;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_left   <= '0;
      pre_odd    <= 1'b0;
      frame_open <= 1'b0;
    end else begin
      if (start_pre) begin
        pre_left <= len_eff - LEN_W'(1);
        pre_odd  <= 1'b1;
      end else if (slot_start && pre_cont) begin
        pre_left <= pre_left - LEN_W'(1);
        pre_odd  <= ~pre_odd;
      end
      if (accept && s_last)         frame_open <= 1'b0;
      else if (start_pre || accept) frame_open <= 1'b1;
    end
  end
endmodule

// File: rtl/lenc_symbol.sv
module lenc_symbol
  import lenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slot_start,
  input  logic      slot_mid,
  input  enc_mode_e mode,
  input  logic      enc_bit,
  input  logic      force_idle,
  output logic      line_q,
  output enc_mode_e cur_mode,
  output logic      cur_force
);
  logic [1:0] halves;
  logic       pend;

  assign halves = encode_halves(mode, enc_bit, line_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= 1'b1;
      pend      <= 1'b1;
      cur_mode  <= ENC_NRZ;
      cur_force <= 1'b1;
    end else if (slot_start) begin
      line_q    <= force_idle ? 1'b1 : halves[1];
      pend      <= force_idle ? 1'b1 : halves[0];
      cur_mode  <= mode;
      cur_force <= force_idle;
    end else if (slot_mid) begin
      line_q    <= pend;
    end
  end
endmodule

// File: rtl/lenc_top.sv
module lenc_top
  import lenc_pkg::*;
#(
  parameter int PRE_MAX = 8,
  parameter int LEN_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_pre_en,
  input  logic [LEN_W-1:0] cfg_pre_len,
  input  logic             cfg_invert,
  input  logic             cfg_idle_high,
  input  logic             idle_bit,
  input  logic             s_valid,
  input  logic             s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             line_out
);
  enc_mode_e mode;
  logic      slot_start, slot_mid;
  logic      accept, pre_active, force_idle, enc_bit, frame_open;
  enc_mode_e cur_mode;
  logic      cur_force;

  assign mode = enc_mode_e'(cfg_mode);

  lenc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .slot_start(slot_start), .slot_mid(slot_mid)
  );

  lenc_seq #(.PRE_MAX(PRE_MAX), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .mode(mode),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_len(cfg_pre_len),
    .cfg_invert(cfg_invert), .cfg_idle_high(cfg_idle_high),
    .idle_bit(idle_bit), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .accept(accept),
    .pre_active(pre_active), .force_idle(force_idle),
    .enc_bit(enc_bit), .frame_open(frame_open)
  );

  lenc_symbol u_sym (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_mid(slot_mid),
    .mode(mode), .enc_bit(enc_bit), .force_idle(force_idle),
    .line_q(line_out), .cur_mode(cur_mode), .cur_force(cur_force)
  );
endmodule

// File: rtl/lenc_checks.sv
module lenc_checks
  import lenc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      half_en,
  input logic      s_ready,
  input logic      line_out,
  input logic      slot_start,
  input logic      slot_mid,
  input logic      force_idle,
  input logic      pre_active,
  input enc_mode_e mode,
  input enc_mode_e cur_mode,
  input logic      cur_force
);
  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> half_en); // R2

  AST_READY_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    slot_mid |-> !s_ready); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_out)); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle |=> line_out); // R10

  AST_PRE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pre_active |-> !s_ready); // R6

  AST_FM_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !force_idle && (mode == ENC_FM0 || mode == ENC_FM1))
    |=> line_out != $past(line_out)); // R4

  AST_MID_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_mid && !cur_force && (cur_mode == ENC_MAN || cur_mode == ENC_DMAN))
    |=> line_out != $past(line_out)); // R5

  AST_NRZ_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_mid && !cur_force && (cur_mode == ENC_NRZ || cur_mode == ENC_NRZI_M ||
     cur_mode == ENC_NRZI_S || cur_mode == ENC_RSVD))
    |=> $stable(line_out)); // R3
endmodule

bind lenc_top lenc_checks u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .s_ready(s_ready),
  .line_out(line_out), .slot_start(slot_start), .slot_mid(slot_mid),
  .force_idle(force_idle), .pre_active(pre_active), .mode(mode),
  .cur_mode(cur_mode), .cur_force(cur_force)
);

// File: tb/lenc_top_bench.sv
`timescale 1ns/1ps
module lenc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_en = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic       cfg_pre_en = 1'b0;
  logic [3:0] cfg_pre_len = 4'd0;
  logic       cfg_invert = 1'b0;
  logic       cfg_idle_high = 1'b1;
  logic       idle_bit = 1'b0;
  logic       s_valid = 1'b0, s_data = 1'b0, s_last = 1'b0;
  logic       s_ready, line_out;

  int checks = 0;
  int failures = 0;
  logic mdl_lvl;
  logic dq [0:15];

  always #2 clk = ~clk;

  lenc_top u_lenc_top (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .cfg_mode(cfg_mode),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_len(cfg_pre_len),
    .cfg_invert(cfg_invert), .cfg_idle_high(cfg_idle_high),
    .idle_bit(idle_bit), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .line_out(line_out)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected halves, written as transition flags over the previous level.
  function automatic logic [1:0] ref_pair(int m, logic b, logic lv);
    logic tb, tm, a;
    tb = 0; tm = 0;
    case (m)
      1: tb = b;
      2: tb = !b;
      3: begin tb = 1; tm = !b; end
      4: begin tb = 1; tm = b; end
      6: begin tb = !b; tm = 1; end
      default: ;
    endcase
    if (m == 5) return {b, !b};
    if (m == 0 || m == 7) return {b, b};
    a = lv ^ tb;
    return {a, a ^ tm};
  endfunction

  function automatic logic ref_pre(int m, int k);
    if (m == 1 || m == 4) return 1'b0;
    if (m == 5) return (k % 2 == 0);
    return 1'b1;
  endfunction

  function automatic string mode_tag(int m);
    if (m == 3 || m == 4) return "R4";
    if (m == 5 || m == 6) return "R5";
    return "R3";
  endfunction

  // One bit slot: two strobes; returns handshake result and both halves.
  task automatic slot(input logic v, input logic d, input logic last,
                      output logic acc, output logic h0, output logic h1);
    @(negedge clk);
    s_valid = v; s_data = d; s_last = last; half_en = 1'b1;
    #1 acc = s_ready && v;
    @(negedge clk);
    half_en = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    h0 = line_out;
    @(negedge clk);
    chk(line_out == h0, "R2 hold between strobes", line_out, h0);
    chk(s_ready == 1'b0, "R2 ready without strobe", s_ready, 0);
    half_en = 1'b1;
    #1 chk(s_ready == 1'b0, "R2 ready on second half", s_ready, 0);
    @(negedge clk);
    half_en = 1'b0;
    h1 = line_out;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; half_en = 1'b0; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl_lvl = 1'b1;
  endtask

  // npre lock-up slots, then n data bits from dq.
  task automatic run_frame(input int npre, input int n, input logic last, input string tag);
    logic acc, h0, h1, b;
    logic [1:0] e;
    int m;
    m = int'(cfg_mode);
    for (int s = 0; s < npre + n; s++) begin
      int di;
      di = (s < npre) ? 0 : s - npre;
      slot(1'b1, dq[di], last && (s == npre + n - 1), acc, h0, h1);
      if (s < npre) begin
        chk(acc == 1'b0, "R6 ready low in lock-up", acc, 0);
        b = ref_pre(m, s);
        e = ref_pair(m, b, mdl_lvl);
        chk({h0, h1} == e, "R7 lock-up symbol", {h0, h1}, e);
      end else begin
        chk(acc == 1'b1, {tag, " data taken (R6)"}, acc, 1);
        b = dq[di] ^ cfg_invert;
        e = ref_pair(m, b, mdl_lvl);
        chk({h0, h1} == e, {tag, " data symbol"}, {h0, h1}, e);
      end
      mdl_lvl = e[0];
    end
  endtask

  task automatic idle_slots(input int k, input string tag);
    logic acc, h0, h1;
    logic [1:0] e;
    for (int s = 0; s < k; s++) begin
      slot(1'b0, 1'b0, 1'b0, acc, h0, h1);
      if (cfg_idle_high) e = 2'b11;
      else e = ref_pair(int'(cfg_mode), idle_bit ^ cfg_invert, mdl_lvl);
      chk({h0, h1} == e, tag, {h0, h1}, e);
      mdl_lvl = e[0];
    end
  endtask

  task automatic load_bits(input logic [15:0] v);
    for (int i = 0; i < 16; i++) dq[i] = v[15 - i];
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(line_out == 1'b1, "R1 line high in reset", line_out, 1);
    chk(s_ready == 1'b0, "R1 ready low in reset", s_ready, 0);
    do_reset();
    chk(line_out == 1'b1, "R1 line high after reset", line_out, 1);
  endtask

  task automatic t_all_modes();
    load_bits(16'b1011_0010_0000_0000);
    for (int m = 0; m < 8; m++) begin
      do_reset();
      cfg_mode = 3'(m); cfg_pre_en = 1; cfg_pre_len = 4'd4;
      cfg_invert = 0; cfg_idle_high = 1;
      run_frame(4, 7, 1'b1, mode_tag(m));
      idle_slots(2, "R10 forced high idle");
    end
  endtask

  task automatic t_pre_len();
    load_bits(16'b0110_0000_0000_0000);
    cfg_mode = 3'd3; cfg_pre_en = 1; cfg_invert = 0; cfg_idle_high = 1;
    do_reset(); cfg_pre_len = 4'd0;  run_frame(0, 3, 1'b1, "R6 len zero");
    do_reset(); cfg_pre_len = 4'd8;  run_frame(8, 3, 1'b1, "R6 len max");
    do_reset(); cfg_pre_len = 4'd12; run_frame(8, 3, 1'b1, "R6 len clamped");
    do_reset(); cfg_pre_en = 0; cfg_pre_len = 4'd4; run_frame(0, 3, 1'b1, "R6 disabled");
    cfg_pre_en = 1;
  endtask

  task automatic t_invert();
    load_bits(16'b1100_1010_0000_0000);
    cfg_invert = 1; cfg_idle_high = 0; idle_bit = 1; cfg_pre_en = 1; cfg_pre_len = 4'd2;
    for (int m = 0; m < 7; m += 5) begin
      do_reset(); cfg_mode = 3'(m);
      run_frame(2, 8, 1'b1, "R9 inverted");
      idle_slots(3, "R9 inverted idle bit");
    end
    do_reset(); cfg_mode = 3'd1;
    run_frame(2, 8, 1'b1, "R9 inverted NRZI");
    cfg_invert = 0; cfg_idle_high = 1;
  endtask

  task automatic t_gap();
    load_bits(16'b1001_1100_0000_0000);
    do_reset();
    cfg_mode = 3'd6; cfg_pre_en = 1; cfg_pre_len = 4'd3; cfg_idle_high = 1; cfg_invert = 0;
    run_frame(3, 4, 1'b0, "R5 frame part");
    idle_slots(2, "R10 gap forced high");
    run_frame(0, 3, 1'b1, "R8 no lock-up after gap");
    run_frame(3, 2, 1'b1, "R8 lock-up after close");
  endtask

  task automatic t_idle_encode();
    do_reset();
    cfg_idle_high = 0; cfg_invert = 0;
    cfg_mode = 3'd2; idle_bit = 0; idle_slots(3, "R10 idle encoded NRZI-space");
    cfg_mode = 3'd3; idle_bit = 1; idle_slots(3, "R10 idle encoded FM0");
    cfg_mode = 3'd0; idle_bit = 0; idle_slots(2, "R10 idle encoded NRZ");
    cfg_idle_high = 1;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_all_modes();
    t_pre_len();
    t_invert();
    t_gap();
    t_idle_encode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule